// File: doc/BRIEF.md
# Streaming Pattern Scanner (Parallel-State Automaton)

This block watches a byte stream and raises a one-cycle flag each time the bytes seen so far end with a string of the fixed pattern `ab(c|d)+e?f`. That pattern has an alternation, a one-or-more repetition and an optional symbol. The pattern is built in as a set of per-position state flip-flops, one for each symbol position. Several positions can be live in the same cycle, so overlapping partial matches are followed together and nothing is ever re-scanned. The search is unanchored: a match may begin on any byte of the stream.

Bytes arrive on a valid/ready stream at up to one byte per clock. The block never applies back-pressure: `in_ready` is held high outside reset, and a byte is taken on every rising edge where `in_valid` is high. A producer may stall by lowering `in_valid` for any number of cycles; the scan state is frozen for those cycles. A synchronous `clr` drops every partial match. The six character codes are parameters, so the same structure serves any pattern of this shape.

Top module: `regex_nfa_scan`

## Requirements
- R1: After reset, and in the cycle after `clr` is high on a rising edge, no partial match survives and `match` is low. `clr` takes priority over a valid byte on the same edge; that byte is dropped.
- R2: A valid byte that completes a pattern string makes `match` high for exactly the one clock cycle after the edge that accepts it (e.g. stream `abcf` flags on `f`).
- R3: The `(c|d)+` part accepts one or more bytes, each either `c` or `d`, in any mix (`abccddcf` matches); with none of them (`abf`) there is no match.
- R4: The `e?` part accepts zero or one `e` before `f` (`abcf` and `abcef` match); two `e` (`abceef`) or an `e` with no `c`/`d` before it (`abef`) do not match.
- R5: The search is unanchored: a match is found at any stream offset, including after failed prefixes that overlap it (`aabcf`, `xxabdf`, `abababcf`).
- R6: A cycle with `in_valid` low leaves the scan state unchanged, and the byte on `in_data` in that cycle has no effect; `match` is low in the cycle after such an idle cycle.
- R7: `in_ready` is high in every cycle outside reset; the block never stalls the producer.
- R8: Back-to-back matches are each flagged (`abcfabdf` flags twice); a byte that cannot extend a completed match (`abcff`) flags nothing further.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all partial matches |
| in_data | input | 8 | Stream byte (DATA_W bits) |
| in_valid | input | 1 | Byte on `in_data` is present this cycle |
| in_ready | output | 1 | Block accepts a byte this cycle (always high outside reset) |
| match | output | 1 | One-cycle pulse: the last accepted byte ended a pattern string |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and the character codes `a`, `b`, `c`, `d`, `e`, `f`, so patterns can be written as plain ASCII strings. With those values, every construct of the pattern is reachable with short strings: repetition with mixed `c`/`d`, the optional `e` present, absent and doubled, overlapping false starts, back-to-back matches, idle cycles carrying a would-be completing byte, and a clear that collides with a valid byte.

// File: rtl/regex_pkg.sv
package regex_pkg;
  localparam int DATA_W = 8;
  localparam int NSTATE = 5;   // one flop per pattern position: a b [cd] e f
  localparam int NALT   = 2;   // widest symbol class (c|d)

  // Entry i: bit j set means state j may lead into state i.
  localparam logic [NSTATE-1:0][NSTATE-1:0] PRED_MASK = {
    5'b01100,  // f   <- [cd] or e
    5'b00100,  // e   <- [cd]
    5'b00110,  // [cd]<- b or itself (one-or-more)
    5'b00001,  // b   <- a
    5'b00000   // a   <- start only
  };
  localparam logic [NSTATE-1:0] START_MASK = 5'b00001;
  localparam logic [NSTATE-1:0] FINAL_MASK = 5'b10000;
endpackage

// File: rtl/sym_match.sv
module sym_match #(
  parameter int W    = 8,
  parameter int NALT = 2,
  parameter logic [NALT*W-1:0] CHARS = '0
) (
  input  logic [W-1:0] data,
  output logic         hit
);
  logic [NALT-1:0] eq;
  for (genvar k = 0; k < NALT; k++) begin : g_cmp
    assign eq[k] = (data == CHARS[k*W +: W]);
  end
  assign hit = |eq;
endmodule

// File: rtl/nfa_state.sv
module nfa_state
  import regex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [NSTATE-1:0] hit,
  output logic [NSTATE-1:0] state
);
  logic [NSTATE-1:0] nxt;

  for (genvar i = 0; i < NSTATE; i++) begin : g_pos
    assign nxt[i] = hit[i] & (START_MASK[i] | (|(state & PRED_MASK[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (clr)  state <= '0;
    else if (step) state <= nxt;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == '0));  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(state));  // R6
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (!state[1] || $past(state[0])));  // R2
  AST_E_AFTER_CD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (!state[3] || $past(state[2])));  // R4
endmodule

// File: rtl/regex_nfa_scan.sv
module regex_nfa_scan
  import regex_pkg::*;
#(
  parameter logic [DATA_W-1:0] C_A = 8'h61,
  parameter logic [DATA_W-1:0] C_B = 8'h62,
  parameter logic [DATA_W-1:0] C_C = 8'h63,
  parameter logic [DATA_W-1:0] C_D = 8'h64,
  parameter logic [DATA_W-1:0] C_E = 8'h65,
  parameter logic [DATA_W-1:0] C_F = 8'h66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              match
);
  localparam logic [NSTATE-1:0][NALT-1:0][DATA_W-1:0] SYMS = {
    {C_F, C_F}, {C_E, C_E}, {C_C, C_D}, {C_B, C_B}, {C_A, C_A}
  };

  logic [NSTATE-1:0] hit;
  logic [NSTATE-1:0] state;
  logic              step;
  logic              fresh_q;
  logic              rdy_q;

  assign step     = in_valid & rdy_q;
  assign in_ready = rdy_q;

  for (genvar i = 0; i < NSTATE; i++) begin : g_sym
    sym_match #(.W(DATA_W), .NALT(NALT), .CHARS(SYMS[i])) i_sym (
      .data(in_data),
      .hit (hit[i])
    );
  end

  nfa_state i_core (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .step (step),
    .hit  (hit),
    .state(state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      fresh_q <= step & ~clr;
      rdy_q   <= 1'b1;
    end
  end

  assign match = fresh_q & (|(state & FINAL_MASK));

  AST_MATCH_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(in_valid && !clr));  // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);  // R8
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);  // R7
endmodule

// File: tb/test_regex_nfa_scan.sv
`timescale 1ns/1ps
module test_regex_nfa_scan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       match;

  int n_checks = 0;
  int n_fail   = 0;
  bit run_mon  = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  regex_nfa_scan i_regex_nfa_scan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .match(match)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: after each edge, compare match with the oldest expectation.
  always @(posedge clk) begin
    #1;
    if (run_mon && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(match, it.exp, it.tag);
      check(in_ready, 1'b1, "R7 ready");
    end
  end

  task automatic drive(input logic [7:0] b, input bit v, input bit c,
                       input bit exp, input string tag);
    @(negedge clk);
    in_data = b; in_valid = v; clr = c;
    q.push_back('{exp, tag});
  endtask

  task automatic send_str(input string s, input string e, input string tag);
    for (int i = 0; i < s.len(); i++)
      drive(s[i], 1'b1, 1'b0, e[i] == "1", tag);
  endtask

  task automatic do_clr();
    drive(8'h00, 1'b0, 1'b1, 1'b0, "R1 clr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(match, 1'b0, "R1 reset match");
    check(in_ready, 1'b0, "R7 ready low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(match, 1'b0, "R1 after reset");
    check(in_ready, 1'b1, "R7 ready after reset");
    run_mon = 1'b1;

    send_str("abcf", "0001", "R2 basic");                do_clr();
    send_str("abccddcf", "00000001", "R3 repeat mix");   do_clr();
    send_str("abf", "000", "R3 no repeat");              do_clr();
    send_str("abdcf", "00001", "R3 d then c");           do_clr();
    send_str("abcef", "00001", "R4 optional e");         do_clr();
    send_str("abceef", "000000", "R4 double e");         do_clr();
    send_str("abef", "0000", "R4 e without cd");         do_clr();
    send_str("aabcf", "00001", "R5 overlap a");          do_clr();
    send_str("xxabdf", "000001", "R5 offset");           do_clr();
    send_str("abababcf", "00000001", "R5 repeated prefix"); do_clr();
    send_str("abcfabdf", "00010001", "R8 back to back"); do_clr();
    send_str("abcff", "00010", "R8 extra f");            do_clr();

    // R6: idle cycles carry bytes that must be ignored
    send_str("abc", "000", "R6 prefix");
    drive("f", 1'b0, 1'b0, 1'b0, "R6 idle f ignored");
    drive("x", 1'b0, 1'b0, 1'b0, "R6 idle x ignored");
    send_str("f", "1", "R6 state held");
    drive("f", 1'b0, 1'b0, 1'b0, "R6 pulse drops when idle");
    drive("a", 1'b0, 1'b0, 1'b0, "R6 still idle");
    do_clr();

    // R1: clear drops partial matches, and wins over a valid byte
    send_str("abc", "000", "R1 prefix");
    do_clr();
    send_str("f", "0", "R1 cleared state");
    send_str("abd", "000", "R1 prefix2");
    drive("f", 1'b1, 1'b1, 1'b0, "R1 clr beats byte");
    send_str("f", "0", "R1 after clr collision");
    send_str("abcf", "0001", "R1 works after clr");

    drive(8'h00, 1'b0, 1'b0, 1'b0, "R6 tail");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule